// File: doc/BRIEF.md
# Mixed-Width Dual-Port Nibble Memory

This block stores 2048 bits and offers them through two ports of different shape, both on one clock. The byte port sees 256 words of 8 bits. The nibble port sees 512 words of 4 bits. Each port has its own address, write data, write enable and a registered read-data output. Read data appears in the cycle after the address is presented.

The nibble port addresses storage entries directly. Byte word `n` is made of nibble entries `2n` and `2n+1`. The even entry holds bits [7:4] of the byte and the odd entry holds bits [3:0]. Storage is split into one bank per nibble lane, so each bank is a plain equal-width dual-port array that a synthesizer can map onto block memory.

When a port reads and writes the same location in one cycle, the read returns the contents from before the write. When one port reads a location that the other port is writing, the read also returns the old contents. When both ports write the same nibble in one cycle, the byte port's data is kept.

Top module: `mwr_dpram`

## Requirements
- R1: While `rst` is high at a clock edge, both `a_rdata` and `b_rdata` are 0 after that edge.
- R2: One cycle after `a_addr` = n is presented, `a_rdata` holds the byte word n. Bits [7:4] come from nibble entry 2n and bits [3:0] come from entry 2n+1.
- R3: A nibble-port write to entry k can be read on the byte port at word k/2. An even k lands in bits [7:4] and an odd k lands in bits [3:0].
- R4: A byte-port write of value v to word n sets nibble entry 2n to v[7:4] and entry 2n+1 to v[3:0], both in the same cycle.
- R5: A nibble-port write changes only its own entry. The other nibble of the same byte word keeps its value.
- R6: When the byte port writes and reads the same word in one cycle, `a_rdata` returns the value from before that write.
- R7: When the nibble port writes and reads the same entry in one cycle, `b_rdata` returns the value from before that write.
- R8: When one port reads a location that the other port writes in the same cycle, the read returns the value from before the write.
- R9: If both ports write the same nibble entry in one cycle, the byte port's nibble is stored.
- R10: With its write enable low, a port leaves storage unchanged, whatever its write data holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both ports |
| rst | input | 1 | Synchronous active-high reset of the read registers |
| a_we | input | 1 | Byte-port write enable |
| a_addr | input | 8 | Byte-port word address |
| a_wdata | input | 8 | Byte-port write data |
| a_rdata | output | 8 | Byte-port registered read data |
| b_we | input | 1 | Nibble-port write enable |
| b_addr | input | 9 | Nibble-port entry address |
| b_wdata | input | 4 | Nibble-port write data |
| b_rdata | output | 4 | Nibble-port registered read data |

## Verification
The hardest case to reach is a single cycle in which both ports touch the same storage. This includes both ports writing one nibble entry, and one port reading an entry while the other port writes it. The outcome of such a cycle only shows up one or two cycles later. The bench therefore drives both ports in the same cycle on addresses that are chosen to overlap. It does this for both the even entry and the odd entry of a byte word. It then reads both nibbles back through both ports, and compares the results with a nibble-level model that applies the nibble-port write first and the byte-port write after it.

// File: rtl/mwr_pkg.sv
package mwr_pkg;
    localparam int NIB_W   = 4;
    localparam int RATIO   = 2;
    localparam int A_DEPTH = 256;
    localparam int A_DW    = NIB_W * RATIO;
    localparam int A_AW    = $clog2(A_DEPTH);
    localparam int B_DEPTH = A_DEPTH * RATIO;
    localparam int B_AW    = $clog2(B_DEPTH);
    localparam int LANE_W  = $clog2(RATIO);

    typedef logic [A_AW-1:0]   row_t;
    typedef logic [NIB_W-1:0]  nib_t;
    typedef logic [LANE_W-1:0] lane_t;

    typedef struct packed {
        logic we;
        row_t row;
        nib_t data;
    } nib_req_t;

    function automatic row_t b_row(input logic [B_AW-1:0] addr);
        return addr[B_AW-1:LANE_W];
    endfunction

    function automatic lane_t b_lane(input logic [B_AW-1:0] addr);
        return addr[LANE_W-1:0];
    endfunction
endpackage

// File: rtl/mwr_bank.sv
module mwr_bank
    import mwr_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  nib_req_t a_req,
    input  nib_req_t b_req,
    output nib_t     a_q,
    output nib_t     b_q
);
    nib_t mem [A_DEPTH];

    // Byte-port write placed last so it wins a same-row collision
    always_ff @(posedge clk) begin
        if (b_req.we) mem[b_req.row] <= b_req.data;
        if (a_req.we) mem[a_req.row] <= a_req.data;
    end

    // Registered, read-first outputs
    always_ff @(posedge clk) begin
        if (rst) begin
            a_q <= '0;
            b_q <= '0;
        end else begin
            a_q <= mem[a_req.row];
            b_q <= mem[b_req.row];
        end
    end

    AST_A_LANDS: assert property (@(posedge clk) disable iff (rst)
        a_req.we |=> mem[$past(a_req.row)] == $past(a_req.data)); // R4

    AST_B_LANDS: assert property (@(posedge clk) disable iff (rst)
        (b_req.we && !(a_req.we && a_req.row == b_req.row))
        |=> mem[$past(b_req.row)] == $past(b_req.data)); // R5

    AST_A_WINS: assert property (@(posedge clk) disable iff (rst)
        (a_req.we && b_req.we && a_req.row == b_req.row && a_req.data != b_req.data)
        |=> mem[$past(b_req.row)] != $past(b_req.data)); // R9
endmodule

// File: rtl/mwr_b_lane.sv
module mwr_b_lane
    import mwr_pkg::*;
(
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        b_we,
    input  logic [B_AW-1:0]             b_addr,
    input  nib_t                        b_wdata,
    input  logic [RATIO-1:0][NIB_W-1:0] bank_q,
    output nib_req_t [RATIO-1:0]        req,
    output nib_t                        b_rdata
);
    lane_t lane_q;

    for (genvar r = 0; r < RATIO; r++) begin : g_req
        assign req[r].we   = b_we && (b_lane(b_addr) == lane_t'(r));
        assign req[r].row  = b_row(b_addr);
        assign req[r].data = b_wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) lane_q <= '0;
        else     lane_q <= b_lane(b_addr);
    end

    assign b_rdata = bank_q[lane_q];
endmodule

// File: rtl/mwr_dpram.sv
module mwr_dpram
    import mwr_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            a_we,
    input  logic [A_AW-1:0] a_addr,
    input  logic [A_DW-1:0] a_wdata,
    output logic [A_DW-1:0] a_rdata,
    input  logic            b_we,
    input  logic [B_AW-1:0] b_addr,
    input  logic [NIB_W-1:0] b_wdata,
    output logic [NIB_W-1:0] b_rdata
);
    nib_req_t [RATIO-1:0]        a_req;
    nib_req_t [RATIO-1:0]        b_req;
    logic [RATIO-1:0][NIB_W-1:0] a_q;
    logic [RATIO-1:0][NIB_W-1:0] b_q;

    mwr_b_lane u_lane (
        .clk     (clk),
        .rst     (rst),
        .b_we    (b_we),
        .b_addr  (b_addr),
        .b_wdata (b_wdata),
        .bank_q  (b_q),
        .req     (b_req),
        .b_rdata (b_rdata)
    );

    // Lane 0 is the most significant nibble of a byte word
    for (genvar r = 0; r < RATIO; r++) begin : g_bank
        localparam int LO = (RATIO - 1 - r) * NIB_W;

        assign a_req[r].we   = a_we;
        assign a_req[r].row  = a_addr;
        assign a_req[r].data = a_wdata[LO +: NIB_W];
        assign a_rdata[LO +: NIB_W] = a_q[r];

        mwr_bank u_bank (
            .clk   (clk),
            .rst   (rst),
            .a_req (a_req[r]),
            .b_req (b_req[r]),
            .a_q   (a_q[r]),
            .b_q   (b_q[r])
        );
    end

    AST_RST_CLEAR: assert property (@(posedge clk)
        rst |=> (a_rdata == '0 && b_rdata == '0)); // R1
endmodule

// File: tb/mwr_dpram_bench.sv
module mwr_dpram_bench;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       a_we = 1'b0;
    logic [7:0] a_addr = '0;
    logic [7:0] a_wdata = '0;
    logic [7:0] a_rdata;
    logic       b_we = 1'b0;
    logic [8:0] b_addr = '0;
    logic [3:0] b_wdata = '0;
    logic [3:0] b_rdata;

    int checks = 0;
    int fails  = 0;
    logic [3:0] model [512];

    always #4 clk = ~clk;

    mwr_dpram u_mwr_dpram (
        .clk(clk), .rst(rst),
        .a_we(a_we), .a_addr(a_addr), .a_wdata(a_wdata), .a_rdata(a_rdata),
        .b_we(b_we), .b_addr(b_addr), .b_wdata(b_wdata), .b_rdata(b_rdata)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    function automatic logic [7:0] word(input int n);
        return {model[2*n], model[2*n+1]};
    endfunction

    // One cycle on both ports; check outputs against the model
    task automatic cyc(input string req, input bit ca, input bit cb,
                       input logic awe, input int aa, input logic [7:0] awd,
                       input logic bwe, input int ba, input logic [3:0] bwd);
        logic [7:0] ea;
        logic [3:0] eb;
        a_we = awe; a_addr = 8'(aa); a_wdata = awd;
        b_we = bwe; b_addr = 9'(ba); b_wdata = bwd;
        ea = word(aa);
        eb = model[ba];
        if (bwe) model[ba] = bwd;
        if (awe) begin
            model[2*aa]   = awd[7:4];
            model[2*aa+1] = awd[3:0];
        end
        @(negedge clk);
        if (ca) chk({req, " a"}, a_rdata, ea);
        if (cb) chk({req, " b"}, {4'h0, b_rdata}, {4'h0, eb});
        a_we = 1'b0; b_we = 1'b0;
    endtask

    task automatic t_reset;
        repeat (3) @(negedge clk);
        chk("R1", a_rdata, 8'h00);
        chk("R1", {4'h0, b_rdata}, 8'h00);
        rst = 1'b0;
    endtask

    task automatic t_fill;
        for (int n = 0; n < 256; n++)
            cyc("R4", 0, 0, 1, n, 8'((n * 37 + 5) & 255), 0, 0, 4'h0);
        for (int n = 0; n < 256; n++)
            cyc("R2", 1, 0, 0, n, 8'h00, 0, 0, 4'h0);
        for (int k = 0; k < 512; k++)
            cyc("R4", 0, 1, 0, 0, 8'h00, 0, k, 4'h0);
        cyc("R2", 1, 0, 0, 3, 8'h00, 0, 0, 4'h0);
        chk("R2", a_rdata, 8'((3 * 37 + 5) & 255));
    endtask

    task automatic t_b_to_a;
        cyc("R3", 0, 0, 0, 0, 8'h00, 1, 10, 4'hA);
        cyc("R3", 0, 0, 0, 0, 8'h00, 1, 11, 4'h5);
        cyc("R3", 1, 0, 0, 5, 8'h00, 0, 0, 4'h0);
        chk("R3", a_rdata, 8'hA5);
    endtask

    task automatic t_b_partial;
        cyc("R5", 0, 0, 1, 20, 8'h3C, 0, 0, 4'h0);
        cyc("R5", 0, 0, 0, 0, 8'h00, 1, 41, 4'h9);
        cyc("R5", 1, 1, 0, 20, 8'h00, 0, 40, 4'h0);
        chk("R5", a_rdata, 8'h39);
        chk("R5", {4'h0, b_rdata}, 8'h03);
    endtask

    task automatic t_read_first;
        cyc("R6", 0, 0, 1, 7, 8'h11, 0, 0, 4'h0);
        cyc("R6", 1, 0, 1, 7, 8'hE2, 0, 0, 4'h0);
        chk("R6", a_rdata, 8'h11);
        cyc("R6", 1, 0, 0, 7, 8'h00, 0, 0, 4'h0);
        chk("R6", a_rdata, 8'hE2);
        cyc("R7", 0, 0, 0, 0, 8'h00, 1, 99, 4'h4);
        cyc("R7", 0, 1, 0, 0, 8'h00, 1, 99, 4'hB);
        chk("R7", {4'h0, b_rdata}, 8'h04);
        cyc("R7", 0, 1, 0, 0, 8'h00, 0, 99, 4'h0);
        chk("R7", {4'h0, b_rdata}, 8'h0B);
    endtask

    task automatic t_cross;
        cyc("R8", 0, 0, 1, 9, 8'h6D, 0, 0, 4'h0);
        cyc("R8", 0, 1, 1, 9, 8'hF0, 0, 18, 4'h0);
        chk("R8", {4'h0, b_rdata}, 8'h06);
        cyc("R8", 1, 0, 0, 9, 8'h00, 1, 19, 4'h7);
        chk("R8", a_rdata, 8'hF0);
        cyc("R8", 1, 0, 0, 9, 8'h00, 0, 0, 4'h0);
        chk("R8", a_rdata, 8'hF7);
    endtask

    task automatic t_collide;
        cyc("R9", 0, 0, 1, 30, 8'h12, 1, 60, 4'hF);
        cyc("R9", 1, 0, 0, 30, 8'h00, 0, 0, 4'h0);
        chk("R9", a_rdata, 8'h12);
        cyc("R9", 0, 0, 1, 31, 8'h34, 1, 63, 4'hC);
        cyc("R9", 1, 1, 0, 31, 8'h00, 0, 63, 4'h0);
        chk("R9", a_rdata, 8'h34);
        chk("R9", {4'h0, b_rdata}, 8'h04);
        cyc("R9", 0, 0, 1, 40, 8'h5A, 1, 100, 4'h8);
        cyc("R9", 1, 0, 0, 50, 8'h00, 0, 0, 4'h0);
        cyc("R9", 1, 0, 0, 40, 8'h00, 0, 0, 4'h0);
        chk("R9", a_rdata, 8'h5A);
    endtask

    task automatic t_no_we;
        cyc("R10", 0, 0, 1, 60, 8'hC3, 0, 0, 4'h0);
        cyc("R10", 0, 0, 0, 60, 8'hFF, 0, 120, 4'h0);
        cyc("R10", 1, 1, 0, 60, 8'h00, 0, 121, 4'h0);
        chk("R10", a_rdata, 8'hC3);
        chk("R10", {4'h0, b_rdata}, 8'h03);
    endtask

    initial begin
        fork
            begin
                @(negedge clk);
                t_reset();
                t_fill();
                t_b_to_a();
                t_b_partial();
                t_read_first();
                t_cross();
                t_collide();
                t_no_we();
            end
            begin
                repeat (100000) @(posedge clk);
                checks++;
                fails++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule